// File: doc/BRIEF.md
# Limited-Pointer Directory Sharer Entry

This block is the state and update logic of one coherence directory entry. It records which nodes hold a copy of a memory line, using a small set of node-number pointers instead of one presence bit per node. When a new sharer arrives and every pointer is in use, the entry switches to an overflow representation. A static parameter chooses that representation: a single broadcast flag, a replace-a-sharer scheme that names the node which must be invalidated, or a coarse vector with one bit per group of nodes.

Commands enter on a valid/ready channel. Each command has an opcode and a node number. Every accepted command produces exactly one beat on a valid/ready response channel. `cmd_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that is not taken holds all of its fields unchanged. A query returns the set of nodes that must be invalidated, expanded to one bit per node, with the requesting node left out. An add that displaces a sharer returns that sharer's number.

Top module: `dir_limptr_entry`

## Requirements
- R1: After reset, `resp_valid` is 0, `cmd_ready` is 1, and the entry is empty, so a query returns an all-zero mask.
- R2: `cmd_ready` equals `!resp_valid || resp_ready`. While `resp_valid && !resp_ready`, the response fields stay stable, and a command offered in that time is not taken and has no effect.
- R3: Opcode 0 (add) with node n stores n in a free pointer slot. Opcode 3 (query) by node q returns `resp_mask`, where bit i is set for each recorded node i other than q.
- R4: Adding a node that is already held in a pointer changes nothing and uses up no pointer.
- R5: Opcode 1 (clear) empties every pointer, clears the broadcast and coarse flags and the coarse vector, and resets the round-robin slot to 0.
- R6: Opcode 2 (set owner) with node n leaves the entry in pointer mode with n as its only sharer.
- R7: Broadcast policy (POLICY=0). An add to a full entry sets a broadcast flag. From then on, a query returns every node except the requester, and further adds have no visible effect.
- R8: Replace policy (POLICY=1). An add of a new node to a full entry overwrites the slot chosen round-robin, starting at slot 0. The response has `resp_victim_vld`=1, `resp_victim_id` = the displaced node, and `resp_mask` = the one-hot mask of that node.
- R9: Coarse policy (POLICY=2). An add to a full entry converts the entry to a vector with bit g for nodes g*GROUP to g*GROUP+GROUP-1, covering every recorded node and the new one. A query then returns every node in each marked group, except the requester.
- R10: In coarse mode, an add sets the group bit of its node. Under the broadcast and coarse policies, `resp_victim_vld` is always 0.
- R11: The response to a command accepted at a clock edge is valid right after that edge. Add, clear and set-owner responses that displace no node carry a zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 add, 1 clear, 2 set owner, 3 query |
| cmd_id | input | ID_W | Node number of the command |
| resp_valid | output | 1 | Response beat present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_mask | output | NODES | Nodes to invalidate (query) or one-hot victim |
| resp_victim_vld | output | 1 | A sharer was displaced by this add |
| resp_victim_id | output | ID_W | Displaced node number |

## Verification
Each response is due one cycle after its command is accepted. The bench drives a command on a falling edge and removes it on the next falling edge, which is after the accepting rising edge, and reads the response at that moment. Queries see the state left by all earlier commands, because the state register and the response register update at the same edge. In the stall test, the response is read on several falling edges while the consumer holds back, and the command offered during the stall is checked afterwards through a query.

// File: rtl/dir_lp_pkg.sv
package dir_lp_pkg;
  localparam logic [1:0] OP_ADD   = 2'd0;
  localparam logic [1:0] OP_CLEAR = 2'd1;
  localparam logic [1:0] OP_OWNER = 2'd2;
  localparam logic [1:0] OP_QUERY = 2'd3;

  localparam int POL_BCAST   = 0;
  localparam int POL_REPLACE = 1;
  localparam int POL_COARSE  = 2;
endpackage

// File: rtl/dir_ptr_match.sv
module dir_ptr_match #(
  parameter int NPTR   = 4,
  parameter int ID_W   = 4,
  parameter int SLOT_W = 2
) (
  input  logic [NPTR-1:0][ID_W-1:0] ptr,
  input  logic [NPTR-1:0]           ptr_vld,
  input  logic [ID_W-1:0]           id,
  output logic                      hit,
  output logic                      full,
  output logic [SLOT_W-1:0]         free_slot
);
  logic [NPTR-1:0] hit_v;

  for (genvar i = 0; i < NPTR; i++) begin : g_cmp
    assign hit_v[i] = ptr_vld[i] && (ptr[i] == id);
  end

  assign hit  = |hit_v;
  assign full = &ptr_vld;

  always_comb begin
    free_slot = '0;
    for (int i = NPTR - 1; i >= 0; i--) begin
      if (!ptr_vld[i]) free_slot = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/dir_mask_expand.sv
module dir_mask_expand #(
  parameter int NODES  = 16,
  parameter int NPTR   = 4,
  parameter int ID_W   = 4,
  parameter int GROUP  = 4,
  parameter int NGRP   = 4
) (
  input  logic [NPTR-1:0][ID_W-1:0] ptr,
  input  logic [NPTR-1:0]           ptr_vld,
  input  logic                      bcast,
  input  logic                      coarse,
  input  logic [NGRP-1:0]           cvec,
  input  logic [ID_W-1:0]           excl_id,
  output logic [NODES-1:0]          mask
);
  logic [NODES-1:0] cmask;
  logic [NODES-1:0] pmask;
  logic [NODES-1:0] self_m;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign cmask[g*GROUP +: GROUP] = {GROUP{cvec[g]}};
  end

  always_comb begin
    pmask = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (ptr_vld[i]) pmask[ptr[i]] = 1'b1;
    end
    self_m = '0;
    self_m[excl_id] = 1'b1;
  end

  always_comb begin
    if (bcast)       mask = '1;
    else if (coarse) mask = cmask;
    else             mask = pmask;
    mask = mask & ~self_m;
  end
endmodule

// File: rtl/dir_limptr_entry.sv
module dir_limptr_entry
  import dir_lp_pkg::*;
#(
  parameter int NODES  = 16,
  parameter int NPTR   = 4,
  parameter int GROUP  = 4,
  parameter int POLICY = POL_BCAST,
  localparam int ID_W  = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_id,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [NODES-1:0] resp_mask,
  output logic             resp_victim_vld,
  output logic [ID_W-1:0]  resp_victim_id
);
  localparam int SLOT_W = (NPTR > 1) ? $clog2(NPTR) : 1;
  localparam int GRP_SH = $clog2(GROUP);
  localparam int GW     = ID_W - GRP_SH;
  localparam int NGRP   = NODES / GROUP;

  logic [NPTR-1:0][ID_W-1:0] ptr_q, ptr_n;
  logic [NPTR-1:0]           vld_q, vld_n;
  logic [SLOT_W-1:0]         rr_q, rr_n;
  logic                      bcast_q, bcast_n;
  logic                      coarse_q, coarse_n;
  logic [NGRP-1:0]           cvec_q, cvec_n;

  logic                      fire;
  logic                      hit, full;
  logic [SLOT_W-1:0]         free_slot;
  logic [NODES-1:0]          qmask;
  logic                      vict_n;
  logic [ID_W-1:0]           vict_id_n;
  logic [NODES-1:0]          vict_mask;

  function automatic logic [GW-1:0] grp_of(input logic [ID_W-1:0] n);
    return n[ID_W-1:GRP_SH];
  endfunction

  assign cmd_ready = !resp_valid || resp_ready;
  assign fire      = cmd_valid && cmd_ready;

  dir_ptr_match #(.NPTR(NPTR), .ID_W(ID_W), .SLOT_W(SLOT_W)) match_i (
    .ptr(ptr_q), .ptr_vld(vld_q), .id(cmd_id),
    .hit(hit), .full(full), .free_slot(free_slot)
  );

  dir_mask_expand #(.NODES(NODES), .NPTR(NPTR), .ID_W(ID_W),
                    .GROUP(GROUP), .NGRP(NGRP)) expand_i (
    .ptr(ptr_q), .ptr_vld(vld_q), .bcast(bcast_q), .coarse(coarse_q),
    .cvec(cvec_q), .excl_id(cmd_id), .mask(qmask)
  );

  always_comb begin
    ptr_n     = ptr_q;
    vld_n     = vld_q;
    rr_n      = rr_q;
    bcast_n   = bcast_q;
    coarse_n  = coarse_q;
    cvec_n    = cvec_q;
    vict_n    = 1'b0;
    vict_id_n = '0;
    case (cmd_op)
      OP_CLEAR, OP_OWNER: begin
        vld_n    = '0;
        rr_n     = '0;
        bcast_n  = 1'b0;
        coarse_n = 1'b0;
        cvec_n   = '0;
        if (cmd_op == OP_OWNER) begin
          ptr_n[0] = cmd_id;
          vld_n[0] = 1'b1;
        end
      end
      OP_ADD: begin
        if (coarse_q) begin
          cvec_n[grp_of(cmd_id)] = 1'b1;
        end else if (bcast_q || hit) begin
          // nothing to record
        end else if (!full) begin
          ptr_n[free_slot] = cmd_id;
          vld_n[free_slot] = 1'b1;
        end else if (POLICY == POL_BCAST) begin
          bcast_n = 1'b1;
        end else if (POLICY == POL_REPLACE) begin
          vict_n       = 1'b1;
          vict_id_n    = ptr_q[rr_q];
          ptr_n[rr_q]  = cmd_id;
          rr_n = (rr_q == SLOT_W'(NPTR - 1)) ? '0 : rr_q + 1'b1;
        end else begin
          coarse_n = 1'b1;
          vld_n    = '0;
          for (int i = 0; i < NPTR; i++) begin
            if (vld_q[i]) cvec_n[grp_of(ptr_q[i])] = 1'b1;
          end
          cvec_n[grp_of(cmd_id)] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    vict_mask = '0;
    vict_mask[vict_id_n] = vict_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      vld_q    <= '0;
      rr_q     <= '0;
      bcast_q  <= 1'b0;
      coarse_q <= 1'b0;
      cvec_q   <= '0;
    end else if (fire) begin
      ptr_q    <= ptr_n;
      vld_q    <= vld_n;
      rr_q     <= rr_n;
      bcast_q  <= bcast_n;
      coarse_q <= coarse_n;
      cvec_q   <= cvec_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_mask       <= '0;
      resp_victim_vld <= 1'b0;
      resp_victim_id  <= '0;
    end else if (fire) begin
      resp_valid      <= 1'b1;
      resp_mask       <= (cmd_op == OP_QUERY) ? qmask : vict_mask;
      resp_victim_vld <= vict_n;
      resp_victim_id  <= vict_id_n;
    end else if (resp_ready) begin
      resp_valid      <= 1'b0;
    end
  end
endmodule

// File: rtl/dir_limptr_chk.sv
module dir_limptr_chk
  import dir_lp_pkg::*;
#(
  parameter int NODES = 16,
  parameter int NPTR  = 4,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [ID_W-1:0]  cmd_id,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic [NODES-1:0] resp_mask,
  input logic             resp_victim_vld,
  input logic [ID_W-1:0]  resp_victim_id,
  input logic [NPTR-1:0]  vld_q,
  input logic             bcast_q,
  input logic             coarse_q
);
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> cmd_ready); // R2
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_mask) && $stable(resp_victim_id)); // R2
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> resp_valid); // R11
  AST_QUERY_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_QUERY |=> !resp_mask[$past(cmd_id)]); // R3
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_CLEAR |=> vld_q == '0 && !bcast_q && !coarse_q); // R5
  AST_OWNER_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_OWNER |=> $countones(vld_q) == 1 && !bcast_q && !coarse_q); // R6
  AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_victim_vld |-> $countones(resp_mask) == 1 && resp_mask[resp_victim_id]); // R8
endmodule

bind dir_limptr_entry dir_limptr_chk #(.NODES(NODES), .NPTR(NPTR), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_id(cmd_id), .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_mask(resp_mask), .resp_victim_vld(resp_victim_vld), .resp_victim_id(resp_victim_id),
  .vld_q(vld_q), .bcast_q(bcast_q), .coarse_q(coarse_q)
);

// File: tb/dir_limptr_entry_tb_top.sv
`timescale 1ns/1ps
module dir_limptr_entry_tb_top;
  import dir_lp_pkg::*;

  localparam int NODES = 16;
  localparam int ID_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [ID_W-1:0] cmd_id = '0;
  logic resp_ready = 1'b1;

  logic rdy_b, rdy_r, rdy_c;
  logic rv_b, rv_r, rv_c;
  logic [NODES-1:0] m_b, m_r, m_c;
  logic vv_b, vv_r, vv_c;
  logic [ID_W-1:0] vi_b, vi_r, vi_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dir_limptr_entry #(.POLICY(POL_BCAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_b),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .resp_valid(rv_b), .resp_ready(resp_ready),
    .resp_mask(m_b), .resp_victim_vld(vv_b), .resp_victim_id(vi_b));
  dir_limptr_entry #(.POLICY(POL_REPLACE)) dut_nb_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_r),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .resp_valid(rv_r), .resp_ready(resp_ready),
    .resp_mask(m_r), .resp_victim_vld(vv_r), .resp_victim_id(vi_r));
  dir_limptr_entry #(.POLICY(POL_COARSE)) dut_cv_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_c),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .resp_valid(rv_c), .resp_ready(resp_ready),
    .resp_mask(m_c), .resp_victim_vld(vv_c), .resp_victim_id(vi_c));

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  id;
    logic [15:0] mb;
    logic [15:0] mr;
    logic [15:0] mc;
    logic        vv;
    logic [3:0]  vid;
  } vec_t;

  // op: 0 add, 1 clear, 2 owner, 3 query
  localparam vec_t TBL [19] = '{
    '{2'd1, 4'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R5 clear
    '{2'd0, 4'd1,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R3 add
    '{2'd0, 4'd5,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R3 add
    '{2'd0, 4'd5,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R4 duplicate
    '{2'd3, 4'd1,  16'h0020, 16'h0020, 16'h0020, 1'b0, 4'd0}, // R3 query
    '{2'd0, 4'd9,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R4 slot still free
    '{2'd0, 4'd8,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R4 fourth pointer
    '{2'd3, 4'd0,  16'h0322, 16'h0322, 16'h0322, 1'b0, 4'd0}, // R4 no overflow yet
    '{2'd0, 4'd2,  16'h0000, 16'h0002, 16'h0000, 1'b1, 4'd1}, // R7 R8 R9 overflow
    '{2'd3, 4'd5,  16'hFFDF, 16'h0304, 16'h0FDF, 1'b0, 4'd0}, // R7 R8 R9 query
    '{2'd0, 4'd13, 16'h0000, 16'h0020, 16'h0000, 1'b1, 4'd5}, // R8 R10 next slot
    '{2'd3, 4'd15, 16'h7FFF, 16'h2304, 16'h7FFF, 1'b0, 4'd0}, // R7 R9 R10 query
    '{2'd0, 4'd9,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R4 duplicate full
    '{2'd3, 4'd9,  16'hFDFF, 16'h2104, 16'hFDFF, 1'b0, 4'd0}, // R3 R7 query
    '{2'd2, 4'd7,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R6 owner
    '{2'd3, 4'd0,  16'h0080, 16'h0080, 16'h0080, 1'b0, 4'd0}, // R6 sole sharer
    '{2'd3, 4'd7,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R3 self excluded
    '{2'd1, 4'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}, // R5 clear
    '{2'd3, 4'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}  // R5 empty
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] id);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_id    = id;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid after reset", {31'd0, rv_b}, 32'd0);
    check("R1 cmd_ready after reset", {31'd0, rdy_b}, 32'd1);
    issue(2'd3, 4'd0);
    check("R1 empty query bcast", {16'd0, m_b}, 32'd0);
    check("R1 empty query replace", {16'd0, m_r}, 32'd0);
    check("R1 empty query coarse", {16'd0, m_c}, 32'd0);
    check("R11 response valid next cycle", {29'd0, rv_b, rv_r, rv_c}, 32'd7);

    for (int s = 0; s < 19; s++) begin
      issue(TBL[s].op, TBL[s].id);
      check($sformatf("R11 table %0d valid", s), {29'd0, rv_b, rv_r, rv_c}, 32'd7);
      check($sformatf("R3 R7 table %0d bcast mask", s), {16'd0, m_b}, {16'd0, TBL[s].mb});
      check($sformatf("R3 R8 table %0d replace mask", s), {16'd0, m_r}, {16'd0, TBL[s].mr});
      check($sformatf("R3 R9 table %0d coarse mask", s), {16'd0, m_c}, {16'd0, TBL[s].mc});
      check($sformatf("R8 table %0d victim flag", s), {31'd0, vv_r}, {31'd0, TBL[s].vv});
      if (TBL[s].vv)
        check($sformatf("R8 table %0d victim id", s), {28'd0, vi_r}, {28'd0, TBL[s].vid});
      check($sformatf("R10 table %0d no victim", s), {30'd0, vv_b, vv_c}, 32'd0);
    end

    // R5: clear after overflow returns to pointer mode
    issue(2'd0, 4'd1);
    issue(2'd0, 4'd2);
    issue(2'd0, 4'd4);
    issue(2'd0, 4'd6);
    issue(2'd0, 4'd8);
    check("R8 fifth add victim", {28'd0, vi_r}, 32'd1);
    issue(2'd1, 4'd0);
    issue(2'd0, 4'd3);
    issue(2'd3, 4'd0);
    check("R5 bcast after clear", {16'd0, m_b}, 32'h0008);
    check("R5 replace after clear", {16'd0, m_r}, 32'h0008);
    check("R5 coarse after clear", {16'd0, m_c}, 32'h0008);

    // R2: back-pressure
    @(negedge clk);
    resp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_id = 4'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 stalled valid", {31'd0, rv_b}, 32'd1);
    check("R2 not ready while stalled", {31'd0, rdy_b}, 32'd0);
    check("R2 stalled mask", {16'd0, m_b}, 32'h0008);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = 4'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 held valid", {31'd0, rv_b}, 32'd1);
    check("R2 held mask", {16'd0, m_b}, 32'h0008);
    resp_ready = 1'b1;
    @(negedge clk);
    check("R2 drained", {31'd0, rv_b}, 32'd0);
    issue(2'd3, 4'd0);
    check("R2 stalled add ignored", {16'd0, m_b}, 32'h0008);
    check("R2 stalled add ignored replace", {16'd0, m_r}, 32'h0008);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule